// File: doc/BRIEF.md
# Protected Startup Configuration Bank

This block holds the few configuration bits a microcontroller fixes at start-up: a watchdog disable, a ROM enable and an enable for making internal reads visible on the external bus. Software reaches them through a small register bus with a registered read port. In normal operation each guarded register takes exactly one write after reset. That write must also arrive within the first 64 bus cycles. Later writes are dropped without effect.

The operating mode is sampled while reset is held. Two of the four modes are special, and a special mode lifts both limits. The special state lives in a flag. Software can clear the flag but never set it again. Firmware that leaves a special mode makes its configuration writes first and then clears the flag. From then on the normal guard applies. The write-once flags and the bus-cycle count built up so far still count.

Top module: `cfg_guard_bank`

## Requirements
- R1: While reset is held, in every mode, `rom_en` becomes 1 and `wdog_off` becomes 0.
- R2: While reset is held, `irv_en` becomes 1 when `mode_sel` is 2'b11 (test), and 0 for 2'b00 (single-chip), 2'b01 (expanded) and 2'b10 (boot).
- R3: A bus cycle is any clock with `bus_ce`=1. When the special flag is clear, a guarded write lands only if fewer than 64 bus cycles came before it since reset. The write's own cycle is not counted. Clocks with `bus_ce`=0 are not counted.
- R4: When the special flag is clear, each guarded register accepts one write per reset. Later writes to it are ignored. The two registers keep separate write-once flags, and reset clears both.
- R5: The special flag resets to `mode_sel[1]`, so it is set for boot and test. While it is set, guarded writes land at any time and any number of times.
- R6: Writing 0 to bit 1 at offset 0x3C clears the special flag. Writing 1 there leaves it unchanged. Once it is clear, R3 and R4 apply, counting bus cycles and writes made before the clear.
- R7: The read data is registered and appears one clock after `addr`. Offset 0x3F returns `wdog_off` in bit 2 and `rom_en` in bit 1. Offset 0x3C returns the special flag in bit 1 and `irv_en` in bit 0. Every other bit and every other offset reads 0.
- R8: A write needs `wr_en`=1, `bus_ce`=1 and an address of 0x3F or 0x3C. Any other write leaves all outputs unchanged. A guarded write at 0x3F loads bits 2 and 1; one at 0x3C loads bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Operating mode, sampled during reset |
| bus_ce | input | 1 | Bus-cycle enable; qualifies writes and advances the window count |
| wr_en | input | 1 | Write strobe |
| addr | input | 6 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| wdog_off | output | 1 | Watchdog disable |
| rom_en | output | 1 | ROM enable |
| irv_en | output | 1 | Internal read visibility enable |

## Verification
A write is tried after 63 and after 64 idle bus cycles, in normal and in special modes. The pair of cases places the edge of the window exactly. The special runs show that the edge disappears. A repeated write to one register, followed by a first write to the other, separates a shared write-once flag from per-register flags. Long stretches with `bus_ce` low confirm that only bus cycles count. A boot-mode run clears the flag late and then attempts a write, which shows that normal protection resumes from the state already reached.

// File: rtl/cfg_guard_pkg.sv
package cfg_guard_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_EXPAND = 2'b01,
    MODE_BOOT   = 2'b10,
    MODE_TEST   = 2'b11
  } op_mode_e;

  localparam int ADDR_W = 6;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] OFF_SYSCFG  = 6'h3F;
  localparam logic [ADDR_W-1:0] OFF_MODECTL = 6'h3C;

  // bit positions inside the two registers
  localparam int BIT_WDOG = 2;
  localparam int BIT_ROM  = 1;
  localparam int BIT_SPEC = 1;
  localparam int BIT_IRV  = 0;

endpackage

// File: rtl/cfg_window_ctr.sv
// Counts bus cycles after reset and saturates, so the write window stays shut.
module cfg_window_ctr #(
  parameter int WIN = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  output logic open
);
  localparam int CW = $clog2(WIN + 1);
  localparam logic [CW-1:0] LIMIT = CW'(WIN);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (tick && (cnt != LIMIT)) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign open = (cnt < LIMIT);
endmodule

// File: rtl/cfg_wonce_reg.sv
// One guarded register: a write lands while bypassed, or in the window if not yet used.
module cfg_wonce_reg #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] rst_val,
  input  logic         wr_hit,
  input  logic         bypass,
  input  logic         open,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q,
  output logic         written
);
  logic take;

  assign take = wr_hit & (bypass | (open & ~written));

  always_ff @(posedge clk) begin
    if (rst) begin
      q       <= rst_val;
      written <= 1'b0;
    end else if (take) begin
      q       <= wdata;
      written <= 1'b1;
    end
  end
endmodule

// File: rtl/cfg_rd_port.sv
// Registered read path; unimplemented bits and offsets return zero.
module cfg_rd_port
  import cfg_guard_pkg::*;
#(
  parameter int              AW       = ADDR_W,
  parameter int              DW       = DATA_W,
  parameter logic [AW-1:0]   CFG_ADDR = OFF_SYSCFG,
  parameter logic [AW-1:0]   CTL_ADDR = OFF_MODECTL
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          wdog,
  input  logic          rom,
  input  logic          spec,
  input  logic          irv,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] nxt;

  always_comb begin
    nxt = '0;
    if (addr == CFG_ADDR) begin
      nxt[BIT_WDOG] = wdog;
      nxt[BIT_ROM]  = rom;
    end else if (addr == CTL_ADDR) begin
      nxt[BIT_SPEC] = spec;
      nxt[BIT_IRV]  = irv;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= nxt;
  end
endmodule

// File: rtl/cfg_guard_bank.sv
module cfg_guard_bank
  import cfg_guard_pkg::*;
#(
  parameter int            AW         = ADDR_W,
  parameter int            DW         = DATA_W,
  parameter int            WIN_CYCLES = 64,
  parameter logic [AW-1:0] CFG_ADDR   = OFF_SYSCFG,
  parameter logic [AW-1:0] CTL_ADDR   = OFF_MODECTL
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    mode_sel,
  input  logic          bus_ce,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          wdog_off,
  output logic          rom_en,
  output logic          irv_en
);
  logic       wr_stb, hit_cfg, hit_ctl;
  logic       spec_q, win_open;
  logic [1:0] sys_q;
  logic [0:0] irv_q;
  logic       cfg_written, ctl_written;
  logic       irv_rst;
  logic       unused_wbits;

  assign wr_stb  = bus_ce & wr_en;
  assign hit_cfg = wr_stb & (addr == CFG_ADDR);
  assign hit_ctl = wr_stb & (addr == CTL_ADDR);
  assign irv_rst = (op_mode_e'(mode_sel) == MODE_TEST);
  assign unused_wbits = ^{wdata[DW-1:BIT_WDOG+1]};

  // special-mode flag: set from the mode at reset, software may only clear it
  always_ff @(posedge clk) begin
    if (rst) begin
      spec_q <= mode_sel[1];
    end else if (hit_ctl && !wdata[BIT_SPEC]) begin
      spec_q <= 1'b0;
    end
  end

  cfg_window_ctr #(.WIN(WIN_CYCLES)) u_win (
    .clk  (clk),
    .rst  (rst),
    .tick (bus_ce),
    .open (win_open)
  );

  cfg_wonce_reg #(.W(2)) u_sys (
    .clk     (clk),
    .rst     (rst),
    .rst_val (2'b01),
    .wr_hit  (hit_cfg),
    .bypass  (spec_q),
    .open    (win_open),
    .wdata   ({wdata[BIT_WDOG], wdata[BIT_ROM]}),
    .q       (sys_q),
    .written (cfg_written)
  );

  cfg_wonce_reg #(.W(1)) u_ctl (
    .clk     (clk),
    .rst     (rst),
    .rst_val (irv_rst),
    .wr_hit  (hit_ctl),
    .bypass  (spec_q),
    .open    (win_open),
    .wdata   (wdata[BIT_IRV]),
    .q       (irv_q),
    .written (ctl_written)
  );

  assign wdog_off = sys_q[1];
  assign rom_en   = sys_q[0];
  assign irv_en   = irv_q[0];

  cfg_rd_port #(
    .AW(AW), .DW(DW), .CFG_ADDR(CFG_ADDR), .CTL_ADDR(CTL_ADDR)
  ) u_rd (
    .clk   (clk),
    .rst   (rst),
    .addr  (addr),
    .wdog  (wdog_off),
    .rom   (rom_en),
    .spec  (spec_q),
    .irv   (irv_en),
    .rdata (rdata)
  );
endmodule

// File: rtl/cfg_guard_chk.sv
module cfg_guard_chk #(
  parameter int            AW       = 6,
  parameter int            DW       = 8,
  parameter int            WIN      = 64,
  parameter logic [AW-1:0] CFG_ADDR = 6'h3F
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    mode_sel,
  input logic          bus_ce,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] rdata,
  input logic          wdog_off,
  input logic          rom_en,
  input logic          irv_en,
  input logic          spec_q,
  input logic          cfg_written,
  input logic          ctl_written
);
  localparam int CW = $clog2(WIN + 1);
  logic [CW-1:0] ce_cnt;

  always_ff @(posedge clk) begin
    if (rst) ce_cnt <= '0;
    else if (bus_ce && (ce_cnt != CW'(WIN))) ce_cnt <= ce_cnt + 1'b1;
  end

  p_rst_vals_r1: assert property (@(posedge clk)
    $fell(rst) |-> (rom_en && !wdog_off));

  p_irv_rst_r2: assert property (@(posedge clk)
    $fell(rst) |-> (irv_en == (mode_sel == 2'b11)));

  p_window_shut_r3: assert property (@(posedge clk) disable iff (rst)
    (!spec_q && ce_cnt >= CW'(WIN)) |=> $stable({wdog_off, rom_en, irv_en}));

  p_once_sys_r4: assert property (@(posedge clk) disable iff (rst)
    (!spec_q && cfg_written) |=> $stable({wdog_off, rom_en}));

  p_once_ctl_r4: assert property (@(posedge clk) disable iff (rst)
    (!spec_q && ctl_written) |=> $stable(irv_en));

  p_spec_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    !spec_q |=> !spec_q);

  p_readback_r7: assert property (@(posedge clk) disable iff (rst)
    (addr == CFG_ADDR) |=> (rdata == DW'({$past(wdog_off), $past(rom_en), 1'b0})));

  p_no_write_r8: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && bus_ce) |=> $stable({wdog_off, rom_en, irv_en}));
endmodule

bind cfg_guard_bank cfg_guard_chk #(
  .AW(AW), .DW(DW), .WIN(WIN_CYCLES), .CFG_ADDR(CFG_ADDR)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .mode_sel    (mode_sel),
  .bus_ce      (bus_ce),
  .wr_en       (wr_en),
  .addr        (addr),
  .rdata       (rdata),
  .wdog_off    (wdog_off),
  .rom_en      (rom_en),
  .irv_en      (irv_en),
  .spec_q      (spec_q),
  .cfg_written (cfg_written),
  .ctl_written (ctl_written)
);

// File: tb/sim_cfg_guard_bank.sv
module sim_cfg_guard_bank;
  timeunit 1ns;
  timeprecision 1ps;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode_sel = 2'b00;
  logic       bus_ce = 1'b0;
  logic       wr_en = 1'b0;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       wdog_off, rom_en, irv_en;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cfg_guard_bank u0 (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .bus_ce(bus_ce), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata),
    .wdog_off(wdog_off), .rom_en(rom_en), .irv_en(irv_en)
  );

  // {mode, idle bus cycles, addr, wdata, expected {wdog_off, rom_en, irv_en}}
  localparam logic [26:0] VECS [8] = '{
    {2'd0, 8'd0,   6'h3F, 8'h04, 3'b100},  // R3 first cycle
    {2'd1, 8'd63,  6'h3F, 8'h06, 3'b110},  // R3 last open cycle
    {2'd1, 8'd64,  6'h3F, 8'h04, 3'b010},  // R3 window shut
    {2'd0, 8'd10,  6'h3C, 8'h01, 3'b011},  // R8 irv via 0x3C
    {2'd3, 8'd100, 6'h3F, 8'h04, 3'b101},  // R5 test, late write
    {2'd2, 8'd200, 6'h3C, 8'h03, 3'b011},  // R5 boot, late write
    {2'd0, 8'd5,   6'h3E, 8'hFF, 3'b010},  // R8 other offset
    {2'd3, 8'd0,   6'h3C, 8'h00, 3'b010}   // R5 test irv cleared
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge
  task automatic cyc(input logic ce, input logic we, input logic [5:0] a, input logic [7:0] d);
    bus_ce = ce; wr_en = we; addr = a; wdata = d;
    @(negedge clk);
  endtask

  task automatic do_reset(input logic [1:0] m);
    rst = 1'b1; mode_sel = m;
    cyc(0, 0, 6'h00, 8'h00);
    cyc(0, 0, 6'h00, 8'h00);
    rst = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc(1, 0, 6'h00, 8'h00);
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    cyc(1, 1, a, d);
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] v);
    cyc(0, 0, a, 8'h00);
    v = rdata;
  endtask

  initial begin
    logic [7:0] v;
    @(negedge clk);

    // vector table
    for (int i = 0; i < 8; i++) begin
      automatic logic [26:0] e = VECS[i];
      do_reset(e[26:25]);
      idle(int'(e[24:17]));
      wr(e[16:11], e[10:3]);
      cyc(0, 0, 6'h00, 8'h00);
      check($sformatf("R3/R5/R8 vector %0d", i), {5'b0, wdog_off, rom_en, irv_en}, {5'b0, e[2:0]});
    end

    // reset state in every mode
    for (int m = 0; m < 4; m++) begin
      do_reset(2'(m));
      check("R1 reset outputs", {6'b0, wdog_off, rom_en}, 8'h01);
      check("R2 reset irv", {7'b0, irv_en}, {7'b0, (m == 3)});
      rd(6'h3F, v);
      check("R7 reset read 0x3F", v, 8'h02);
      rd(6'h3C, v);
      check("R7 reset read 0x3C", v, {6'b0, m[1], (m == 3)});
    end

    // write-once, separate flags
    do_reset(2'b00);
    wr(6'h3F, 8'h04);
    wr(6'h3F, 8'h02);
    rd(6'h3F, v);
    check("R4 second write ignored", v, 8'h04);
    wr(6'h3C, 8'h01);
    cyc(0, 0, 6'h00, 8'h00);
    check("R4 separate flag", {7'b0, irv_en}, 8'h01);

    // reset rearms
    do_reset(2'b00);
    wr(6'h3F, 8'h00);
    cyc(0, 0, 6'h00, 8'h00);
    check("R4 reset rearms", {6'b0, wdog_off, rom_en}, 8'h00);

    // special: repeated writes, unimplemented bits
    do_reset(2'b11);
    idle(5);
    wr(6'h3F, 8'h04);
    wr(6'h3F, 8'h06);
    rd(6'h3F, v);
    check("R5 repeated write", v, 8'h06);
    wr(6'h3F, 8'hFF);
    rd(6'h3F, v);
    check("R7 unused bits zero", v, 8'h06);

    // leaving special mode late
    do_reset(2'b10);
    idle(70);
    wr(6'h3C, 8'h00);
    rd(6'h3C, v);
    check("R6 flag cleared", v, 8'h00);
    wr(6'h3F, 8'h04);
    rd(6'h3F, v);
    check("R6 normal guard resumes", v, 8'h02);
    wr(6'h3C, 8'h02);
    rd(6'h3C, v);
    check("R6 flag cannot be set", v, 8'h00);

    // only bus cycles count
    do_reset(2'b01);
    for (int k = 0; k < 100; k++) cyc(0, 0, 6'h00, 8'h00);
    idle(63);
    wr(6'h3F, 8'h04);
    cyc(0, 0, 6'h00, 8'h00);
    check("R3 non-bus clocks not counted", {7'b0, wdog_off}, 8'h01);

    // write without bus_ce
    do_reset(2'b00);
    cyc(0, 1, 6'h3F, 8'h04);
    cyc(0, 0, 6'h00, 8'h00);
    check("R8 write needs bus_ce", {7'b0, wdog_off}, 8'h00);
    wr(6'h3F, 8'h04);
    cyc(0, 0, 6'h00, 8'h00);
    check("R8 write slot unused", {7'b0, wdog_off}, 8'h01);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule